// File: doc/BRIEF.md
# Barrel Shifter With Carry-Out

This block shifts or rotates a 32-bit operand by an amount read from a register operand. It supports four operations: logical left, logical right, arithmetic right and rotate right. The block returns the shifted value and a carry flag. When flag setting is requested, the carry is the last bit shifted out, with saturation rules for large amounts. When flag setting is not requested, the incoming carry passes through unchanged.

Only the low eight bits of the amount operand are used. Amounts of 32 and above saturate differently for each operation. An amount of zero leaves both the value and the carry untouched. Both outputs are registered, so results appear one clock after the inputs are presented.

Top module: `carry_barrel_shifter`

## Requirements
- R1: Only amount bits [7:0] affect the outputs; bits [31:8] are ignored.
- R2: For op 0 (logical left) and op 1 (logical right), amounts 1 to 31 give the operand shifted with zeros filling the vacated bits.
- R3: Op 2 (arithmetic right) fills vacated bits with operand bit 31; amounts of 32 or more give all bits equal to operand bit 31.
- R4: Logical shifts (op 0 or 1) by 32 or more give a zero result.
- R5: With flag setting and an amount n from 1 to 31, the carry is operand bit (32-n) for op 0 and operand bit (n-1) for ops 1 and 2.
- R6: With flag setting and a logical shift, an amount of exactly 32 sets the carry to bit 0 (op 0) or bit 31 (op 1); an amount above 32 clears it.
- R7: With flag setting, op 2 with an amount of 32 or more sets the carry to operand bit 31.
- R8: An 8-bit amount of zero returns the operand unchanged and returns the incoming carry, for every op.
- R9: Op 3 (rotate right) rotates by the amount modulo 32; a nonzero amount that is a multiple of 32 leaves the value unchanged and, with flag setting, sets the carry to operand bit 31.
- R10: With flag setting, op 3 with amount modulo 32 equal to n in 1 to 31 sets the carry to operand bit (n-1).
- R11: With flag setting off, the carry output equals the incoming carry for all ops and amounts.
- R12: Outputs update one clock after the inputs; while rst_n is low at a rising edge, both outputs become zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 2 | Operation: 0 left, 1 logical right, 2 arithmetic right, 3 rotate right |
| set_flags_i | input | 1 | Compute a new carry when high |
| operand_i | input | 32 | Value to shift |
| amount_i | input | 32 | Shift amount register operand (low 8 bits used) |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted value, registered |
| carry_o | output | 1 | New carry flag, registered |

## Verification
The bench targets the amount boundaries 0, 1, 31, 32, 33 and 255 on every operation, with both carry inputs and flag setting on and off. A design that used the amount modulo 32 for logical shifts would return the operand at 32 instead of zero. A design that treated 32 like 33 would return a cleared carry instead of bit 0 or bit 31. A rotate that skipped the carry update for nonzero multiples of 32 would leave the old carry in place. Random amounts with noisy upper bits expose any decode that looks past bit 7. Random amounts of zero expose a carry that is overwritten when nothing is shifted.

// File: rtl/cbs_pkg.sv
// Shared types for the carry barrel shifter.
package cbs_pkg;
    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } shift_op_e;
endpackage

// File: rtl/cbs_amt_decode.sv
// Amount decoder: keeps the used low bits of the amount operand and flags
// zero, exactly-width and above-width cases. Assumes DATA_W is a power of two
// and AMT_USE bits can hold DATA_W.
module cbs_amt_decode #(
    parameter int DATA_W  = 32,
    parameter int AMT_W   = 32,
    parameter int AMT_USE = 8,
    localparam int SH_W   = $clog2(DATA_W)
) (
    input  logic [AMT_W-1:0] amount_i,
    output logic [SH_W-1:0]  amt_low_o,
    output logic             amt_zero_o,
    output logic             low_zero_o,
    output logic             amt_eq_w_o,
    output logic             amt_over_w_o
);
    logic [AMT_USE-1:0] used;

    // Select the bits that take part in the shift.
    assign used = amount_i[AMT_USE-1:0];

    generate
        if (AMT_W > AMT_USE) begin : g_drop
            logic unused_upper;
            assign unused_upper = ^amount_i[AMT_W-1:AMT_USE];
        end
    endgenerate

    // Classify the used amount.
    always_comb begin
        amt_low_o    = used[SH_W-1:0];
        amt_zero_o   = (used == '0);
        low_zero_o   = (used[SH_W-1:0] == '0);
        amt_eq_w_o   = (used == AMT_USE'(DATA_W));
        amt_over_w_o = (used > AMT_USE'(DATA_W));
    end
endmodule

// File: rtl/cbs_shift_core.sv
// Value path: a log-stage right shifter/rotator. Left shifts are done by
// reversing the bits before and after. Saturation inputs override the
// network for amounts at or above the width.
module cbs_shift_core
    import cbs_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] x_i,
    input  shift_op_e         op_i,
    input  logic [SH_W-1:0]   amt_low_i,
    input  logic              sat_zero_i,
    input  logic              sat_sign_i,
    output logic [DATA_W-1:0] y_o
);
    logic              is_left;
    logic              is_rot;
    logic              fill;
    logic [DATA_W-1:0] x_rev;
    logic [DATA_W-1:0] src;
    logic [DATA_W-1:0] stage [SH_W+1];
    logic [DATA_W-1:0] net_rev;
    logic [DATA_W-1:0] net_out;

    // Decode op into direction, rotate and fill bit.
    always_comb begin
        is_left = (op_i == SH_LSL);
        is_rot  = (op_i == SH_ROR);
        fill    = (op_i == SH_ASR) ? x_i[DATA_W-1] : 1'b0;
    end

    genvar i;
    generate
        for (i = 0; i < DATA_W; i++) begin : g_rev
            assign x_rev[i]   = x_i[DATA_W-1-i];
            assign net_rev[i] = stage[SH_W][DATA_W-1-i];
        end
    endgenerate

    // Network input: reversed operand for left shifts.
    assign src      = is_left ? x_rev : x_i;
    assign stage[0] = src;

    genvar k;
    generate
        for (k = 0; k < SH_W; k++) begin : g_stage
            localparam int S = 1 << k;
            logic [DATA_W-1:0] moved;
            // One stage: shift or rotate by S when amount bit k is set.
            always_comb begin
                if (is_rot) moved = {stage[k][S-1:0], stage[k][DATA_W-1:S]};
                else        moved = {{S{fill}}, stage[k][DATA_W-1:S]};
            end
            assign stage[k+1] = amt_low_i[k] ? moved : stage[k];
        end
    endgenerate

    assign net_out = is_left ? net_rev : stage[SH_W];

    // Apply saturation for large amounts.
    always_comb begin
        if (sat_zero_i)      y_o = '0;
        else if (sat_sign_i) y_o = {DATA_W{x_i[DATA_W-1]}};
        else                 y_o = net_out;
    end
endmodule

// File: rtl/cbs_carry_select.sv
// Carry path: picks the last bit shifted out, applies the per-op rules for
// amounts at or above the width, and passes the incoming carry through for a
// zero amount or when flag setting is off.
module cbs_carry_select
    import cbs_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] x_i,
    input  shift_op_e         op_i,
    input  logic [SH_W-1:0]   amt_low_i,
    input  logic              amt_zero_i,
    input  logic              low_zero_i,
    input  logic              amt_eq_w_i,
    input  logic              amt_over_w_i,
    input  logic              set_flags_i,
    input  logic              carry_i,
    output logic              carry_o
);
    logic [SH_W:0]   left_idx;
    logic [SH_W-1:0] right_idx;
    logic            left_bit;
    logic            right_bit;

    // Bit positions of the last bit shifted out.
    always_comb begin
        left_idx  = (SH_W+1)'(DATA_W) - {1'b0, amt_low_i};
        right_idx = amt_low_i - SH_W'(1);
        left_bit  = x_i[left_idx[SH_W-1:0]];
        right_bit = x_i[right_idx];
    end

    // Choose the new carry according to op and amount class.
    always_comb begin
        carry_o = carry_i;
        if (set_flags_i && !amt_zero_i) begin
            unique case (op_i)
                SH_LSL: begin
                    if (amt_over_w_i)    carry_o = 1'b0;
                    else if (amt_eq_w_i) carry_o = x_i[0];
                    else                 carry_o = left_bit;
                end
                SH_LSR: begin
                    if (amt_over_w_i)    carry_o = 1'b0;
                    else if (amt_eq_w_i) carry_o = x_i[DATA_W-1];
                    else                 carry_o = right_bit;
                end
                SH_ASR: begin
                    if (amt_over_w_i || amt_eq_w_i) carry_o = x_i[DATA_W-1];
                    else                            carry_o = right_bit;
                end
                SH_ROR: begin
                    if (low_zero_i) carry_o = x_i[DATA_W-1];
                    else            carry_o = right_bit;
                end
                default: carry_o = carry_i;
            endcase
        end
    end
endmodule

// File: rtl/carry_barrel_shifter.sv
// Top: registered barrel shifter with carry-out. Inputs are taken every
// clock; result and carry appear one clock later. Reset is synchronous and
// active low and clears both outputs.
module carry_barrel_shifter
    import cbs_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int AMT_W   = 32,
    parameter int AMT_USE = 8,
    localparam int SH_W   = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op_i,
    input  logic              set_flags_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [AMT_W-1:0]  amount_i,
    input  logic              carry_i,
    output logic [DATA_W-1:0] result_o,
    output logic              carry_o
);
    shift_op_e         op;
    logic [SH_W-1:0]   amt_low;
    logic              amt_zero, low_zero, amt_eq_w, amt_over_w;
    logic              is_logical;
    logic [DATA_W-1:0] y_next;
    logic              c_next;

    assign op         = shift_op_e'(op_i);
    assign is_logical = (op == SH_LSL) || (op == SH_LSR);

    cbs_amt_decode #(.DATA_W(DATA_W), .AMT_W(AMT_W), .AMT_USE(AMT_USE)) u_dec (
        .amount_i     (amount_i),
        .amt_low_o    (amt_low),
        .amt_zero_o   (amt_zero),
        .low_zero_o   (low_zero),
        .amt_eq_w_o   (amt_eq_w),
        .amt_over_w_o (amt_over_w)
    );

    cbs_shift_core #(.DATA_W(DATA_W)) u_core (
        .x_i        (operand_i),
        .op_i       (op),
        .amt_low_i  (amt_low),
        .sat_zero_i (is_logical && (amt_eq_w || amt_over_w)),
        .sat_sign_i ((op == SH_ASR) && (amt_eq_w || amt_over_w)),
        .y_o        (y_next)
    );

    cbs_carry_select #(.DATA_W(DATA_W)) u_carry (
        .x_i          (operand_i),
        .op_i         (op),
        .amt_low_i    (amt_low),
        .amt_zero_i   (amt_zero),
        .low_zero_i   (low_zero),
        .amt_eq_w_i   (amt_eq_w),
        .amt_over_w_i (amt_over_w),
        .set_flags_i  (set_flags_i),
        .carry_i      (carry_i),
        .carry_o      (c_next)
    );

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            carry_o  <= 1'b0;
        end else begin
            result_o <= y_next;
            carry_o  <= c_next;
        end
    end
endmodule

// File: rtl/cbs_checker.sv
// Checker: temporal properties on the ports of carry_barrel_shifter.
module cbs_checker #(
    parameter int DATA_W  = 32,
    parameter int AMT_W   = 32,
    parameter int AMT_USE = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        op_i,
    input logic              set_flags_i,
    input logic [DATA_W-1:0] operand_i,
    input logic [AMT_W-1:0]  amount_i,
    input logic              carry_i,
    input logic [DATA_W-1:0] result_o,
    input logic              carry_o
);
    logic primed;

    // Marks cycles whose outputs come from inputs taken outside reset.
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    p_reset_clear_r12: assert property (@(posedge clk)
        !rst_n |=> (result_o == '0) && !carry_o);

    p_zero_amount_r8: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(amount_i[AMT_USE-1:0]) == '0
        |-> (result_o == $past(operand_i)) && (carry_o == $past(carry_i)));

    p_carry_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
        primed && !$past(set_flags_i) |-> carry_o == $past(carry_i));

    p_logical_big_r4: assert property (@(posedge clk) disable iff (!rst_n)
        primed && !$past(op_i[1]) && $past(amount_i[AMT_USE-1:0]) >= AMT_USE'(DATA_W)
        |-> result_o == '0);

    p_asr_big_r7: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(op_i) == 2'd2 && $past(set_flags_i)
        && $past(amount_i[AMT_USE-1:0]) >= AMT_USE'(DATA_W)
        |-> (carry_o == $past(operand_i[DATA_W-1]))
            && (result_o == {DATA_W{$past(operand_i[DATA_W-1])}}));

    p_rotate_whole_r9: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(op_i) == 2'd3
        && $past(amount_i[$clog2(DATA_W)-1:0]) == '0
        |-> result_o == $past(operand_i));
endmodule

bind carry_barrel_shifter cbs_checker #(
    .DATA_W(DATA_W), .AMT_W(AMT_W), .AMT_USE(AMT_USE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .set_flags_i(set_flags_i),
    .operand_i(operand_i), .amount_i(amount_i), .carry_i(carry_i),
    .result_o(result_o), .carry_o(carry_o)
);

// File: tb/sim_carry_barrel_shifter.sv
module sim_carry_barrel_shifter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_i = '0;
    logic        set_flags_i = 1'b0;
    logic [31:0] operand_i = '0;
    logic [31:0] amount_i = '0;
    logic        carry_i = 1'b0;
    logic [31:0] result_o;
    logic        carry_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    carry_barrel_shifter u0 (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .set_flags_i(set_flags_i),
        .operand_i(operand_i), .amount_i(amount_i), .carry_i(carry_i),
        .result_o(result_o), .carry_o(carry_o)
    );

    // Expected {carry, value} from the requirements.
    function automatic logic [32:0] model(int op, logic fl, logic [31:0] x,
                                          logic [31:0] amt, logic cin);
        int a = int'(amt[7:0]);
        int r = a % 32;
        logic [31:0] v;
        logic c;
        v = x; c = cin;
        if (a != 0) begin
            case (op)
                0: if (a < 32) begin v = x << a; c = x[32-a]; end
                   else begin v = '0; c = (a == 32) ? x[0] : 1'b0; end
                1: if (a < 32) begin v = x >> a; c = x[a-1]; end
                   else begin v = '0; c = (a == 32) ? x[31] : 1'b0; end
                2: if (a < 32) begin v = 32'($signed(x) >>> a); c = x[a-1]; end
                   else begin v = {32{x[31]}}; c = x[31]; end
                default: if (r == 0) begin v = x; c = x[31]; end
                   else begin v = (x >> r) | (x << (32 - r)); c = x[r-1]; end
            endcase
        end
        if (!fl) c = cin;
        return {c, v};
    endfunction

    function automatic string tag_of(int op, logic fl, logic [31:0] amt);
        int a = int'(amt[7:0]);
        string t;
        if (a == 0) t = "R8";
        else if (!fl) t = "R11";
        else if (op < 2) t = (a < 32) ? "R2 R5" : "R4 R6";
        else if (op == 2) t = (a < 32) ? "R3 R5" : "R3 R7";
        else t = (a % 32 == 0) ? "R9" : "R9 R10";
        if (amt[31:8] != 0) t = {"R1 ", t};
        return t;
    endfunction

    task automatic compare(string tag, logic [31:0] ev, logic ec);
        n_cmp++;
        if (result_o !== ev || carry_o !== ec) begin
            n_bad++;
            $display("FAIL %s: got value %08h carry %0b, expected value %08h carry %0b",
                     tag, result_o, carry_o, ev, ec);
        end
    endtask

    task automatic apply(int op, logic fl, logic [31:0] x, logic [31:0] amt, logic cin);
        logic [32:0] e;
        @(negedge clk);
        op_i = 2'(op); set_flags_i = fl; operand_i = x; amount_i = amt; carry_i = cin;
        e = model(op, fl, x, amt, cin);
        @(posedge clk); #1;
        compare(tag_of(op, fl, amt), e[31:0], e[32]);
    endtask

    initial begin
        logic [31:0] ops [4] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hA5C3_5A3C, 32'hFFFF_FFFF};
        int amts [6] = '{0, 1, 31, 32, 33, 255};
        void'($urandom(32'd20240611));
        // R12: reset clears outputs even with live inputs.
        operand_i = 32'hDEAD_BEEF; amount_i = 32'd4; set_flags_i = 1'b1; carry_i = 1'b1;
        repeat (3) @(posedge clk);
        #1 compare("R12 reset", 32'h0, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        // R12: one-clock latency after reset release.
        apply(1, 1'b1, 32'h0000_0F00, 32'd8, 1'b0);
        // Directed corner grid.
        for (int op = 0; op < 4; op++)
            for (int ai = 0; ai < 6; ai++)
                for (int xi = 0; xi < 4; xi++)
                    for (int f = 0; f < 2; f++)
                        for (int ci = 0; ci < 2; ci++)
                            apply(op, f[0], ops[xi], amts[ai], ci[0]);
        // R1: upper amount bits ignored.
        apply(0, 1'b1, 32'h4000_0001, 32'hFFFF_FF01, 1'b0);
        apply(3, 1'b1, 32'h1234_5678, 32'h0000_0120, 1'b0);
        // Random mix.
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] amt = $urandom();
            if (i % 3 == 0) amt[31:8] = '0;
            if (i % 7 == 0) amt[7:0] = 8'(($urandom() % 4) * 32);
            if (i % 11 == 0) amt[7:0] = 8'd0;
            apply(int'($urandom() % 4), 1'($urandom()), $urandom(), amt, 1'($urandom()));
        end
        // R12: mid-run reset.
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1 compare("R12 mid reset", 32'h0, 1'b0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule